// File: doc/BRIEF.md
# Burst Bus Initiator Controller

This block is the initiator side of a synchronous burst bus that shares one set of lines between address and data. A local client hands it a command, a start address and a word count. The controller waits for the arbiter's grant and drives one address phase. It then runs data phases until the burst is over. A word moves on a rising edge only when the initiator's ready and the target's ready are both low, and the target has claimed the cycle. Either side can insert wait states by holding its ready high.

A burst can end in four ways. It can finish normally. The target can stop it: with no data this is a retry, after some data it is a disconnect, and without a claim it is an abort. The arbiter can withdraw the grant. Nobody may claim the cycle at all, which is a master abort. In every case the controller raises a one-cycle completion strobe carrying an outcome code and the number of words that moved. After a lost grant, the client can resume the burst from that count.

Top module: `burst_initiator`

## Requirements
- R1: While in reset and while idle, frame_n and irdy_n are high, ad_oe is low and done is low; req_ready is high only when idle.
- R2: Once a request is accepted and gnt_n is sampled low, there is exactly one address cycle: frame_n=0, irdy_n=1, ad_oe=1, ad_out=address, cbe_n=command. In the next cycle irdy_n=0 and cbe_n=4'b0000 (all bytes enabled).
- R3: A word moves, and xfer is high, only in a data cycle where trdy_n=0 and dev_sel_n=0. Wait states move nothing and keep the same write word on ad_out.
- R4: frame_n goes high in the data cycle in which exactly one transfer remains. On the edge after the final transfer, irdy_n and frame_n are high and done pulses for one cycle with the count.
- R5: When command bit 0 is 1 the burst is a write: ad_oe=1 and ad_out=wr_data in data cycles. When command bit 0 is 0 it is a read: ad_oe=0 in data cycles and rd_data follows ad_in.
- R6: If stop_n=0 is sampled before any word has moved, the outcome is retry (code 1) and the count is 0.
- R7: If stop_n=0 is sampled after at least one word has moved, the outcome is disconnect (code 2). The count includes a word that moves on the same edge as the stop.
- R8: stop_n=0 sampled while dev_sel_n=1 gives target abort (code 4). No word moves on that edge.
- R9: If gnt_n is sampled high during a burst, frame_n is high from the next cycle. Exactly one more word moves, and the outcome is preempted (code 3) with the count so far.
- R10: If dev_sel_n stays high for TMO data cycles, the outcome is master abort (code 5) with count 0.
- R11: A stop sampled on the edge that moves the final requested word still gives outcome complete (code 0) with the full count.
- R12: While gnt_n is high after a request is accepted, no address phase starts and frame_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus signals are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client offers a burst request |
| req_cmd | input | 4 | Bus command; bit 0 set means write |
| req_addr | input | AW | Start address |
| req_len | input | LEN_W | Words requested (0 is treated as 1) |
| req_ready | output | 1 | Controller idle and accepting a request |
| wr_data | input | AW | Write word for the current position |
| rd_data | output | AW | Read word, valid while xfer is high |
| xfer | output | 1 | A word moves at the coming edge |
| done | output | 1 | One-cycle completion strobe |
| done_status | output | 3 | Outcome: 0 complete, 1 retry, 2 disconnect, 3 preempted, 4 target abort, 5 master abort |
| done_count | output | LEN_W | Words moved, valid with done |
| gnt_n | input | 1 | Arbiter grant, low asserted |
| frame_n | output | 1 | Burst framing, low asserted |
| irdy_n | output | 1 | Initiator ready, low asserted |
| trdy_n | input | 1 | Target ready, low asserted |
| stop_n | input | 1 | Target stop request, low asserted |
| dev_sel_n | input | 1 | Target claim, low asserted |
| cbe_n | output | 4 | Command in the address cycle, byte enables in data cycles |
| ad_out | output | AW | Address/data value driven by the initiator |
| ad_oe | output | 1 | Initiator drives the address/data lines |
| ad_in | input | AW | Address/data value seen from the target |

## Verification
Two pairs of events can land on the same edge. A target stop can meet the final word of the burst, and a target stop can meet a word moved with data. The bench runs a two-word burst with stop_n and trdy_n both low on the last data cycle. It expects complete with the full count, not disconnect. It also runs a longer burst with a stop plus data partway through and expects the stopping word in the count. The withdrawn grant is tested against a word moved on the same edge. Exactly one further word must follow with frame_n already high.

// File: rtl/burst_init_pkg.sv
// Shared types for the burst initiator: controller states and outcome codes.
package burst_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARB  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_TERM = 3'd4
    } ctl_state_t;

    typedef enum logic [2:0] {
        END_OK      = 3'd0,
        END_RETRY   = 3'd1,
        END_DISC    = 3'd2,
        END_PREEMPT = 3'd3,
        END_TABORT  = 3'd4,
        END_MABORT  = 3'd5
    } end_code_t;

    localparam logic [3:0] BE_ALL = 4'b0000;
    localparam logic [3:0] BE_NONE = 4'b1111;

endpackage

// File: rtl/bi_word_tracker.sv
// Word tracker: holds the burst total, the words moved and the words left.
// Assumes load and step never occur together; a zero length is raised to one.
module bi_word_tracker #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             step,
    output logic [LEN_W-1:0] moved,
    output logic             last_one,
    output logic             next_zero,
    output logic             next_full
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] total_q;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] moved_q;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] moved_nx;

    assign len_eff  = (len == '0) ? ONE : len;
    assign moved_nx = moved_q + (step ? ONE : '0);

    // Counter update: reload at the address phase, advance on each moved word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= ONE;
            left_q  <= '0;
            moved_q <= '0;
        end else if (load) begin
            total_q <= len_eff;
            left_q  <= len_eff;
            moved_q <= '0;
        end else if (step) begin
            left_q  <= left_q - ONE;
            moved_q <= moved_nx;
        end
    end

    assign moved     = moved_q;
    assign last_one  = (left_q <= ONE);
    assign next_zero = (moved_nx == '0);
    assign next_full = (moved_nx == total_q);
endmodule

// File: rtl/bi_claim_timer.sv
// Claim timer: counts unclaimed data cycles and flags a master abort when
// TMO such cycles pass. Assumes arm pulses once before each data phase.
module bi_claim_timer #(
    parameter int TMO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    input  logic claim_n,
    output logic expire
);
    localparam int TW = (TMO < 2) ? 1 : $clog2(TMO);
    localparam logic [TW-1:0] LIMIT = TW'(TMO - 1);

    logic [TW-1:0] tick_q;
    logic          claimed_q;

    // Tick update: clear on arm, latch a claim, else count idle data cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q    <= '0;
            claimed_q <= 1'b0;
        end else if (arm) begin
            tick_q    <= '0;
            claimed_q <= 1'b0;
        end else if (active) begin
            if (!claim_n)
                claimed_q <= 1'b1;
            else if (!claimed_q && tick_q != LIMIT)
                tick_q <= tick_q + TW'(1);
        end
    end

    assign expire = active && !claimed_q && claim_n && (tick_q == LIMIT);
endmodule

// File: rtl/bi_seq_fsm.sv
// Sequencer: walks idle, arbitration, address, data and termination, decides
// the outcome code, and tracks an arbiter-forced wind-down.
// Assumes the data path reports moves and remaining words each data cycle.
module bi_seq_fsm
    import burst_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       gnt_n,
    input  logic       stop_n,
    input  logic       dev_sel_n,
    input  logic       move,
    input  logic       last_one,
    input  logic       next_zero,
    input  logic       next_full,
    input  logic       expire,
    output ctl_state_t state,
    output logic       final_beat,
    output end_code_t  outcome
);
    ctl_state_t state_q, state_nx;
    end_code_t  code_q, code_nx;
    logic       wind_q, wind_nx;

    assign final_beat = last_one || wind_q;

    // Next-state and outcome decision for each sampled edge.
    always_comb begin
        state_nx = state_q;
        code_nx  = code_q;
        wind_nx  = wind_q;
        case (state_q)
            ST_IDLE: if (req_valid) state_nx = ST_ARB;
            ST_ARB:  if (!gnt_n) state_nx = ST_ADDR;
            ST_ADDR: begin
                state_nx = ST_DATA;
                wind_nx  = gnt_n;
            end
            ST_DATA: begin
                if (gnt_n) wind_nx = 1'b1;
                if (!stop_n && dev_sel_n) begin
                    state_nx = ST_TERM;
                    code_nx  = END_TABORT;
                end else if (move && final_beat) begin
                    state_nx = ST_TERM;
                    code_nx  = next_full ? END_OK : END_PREEMPT;
                end else if (!stop_n) begin
                    state_nx = ST_TERM;
                    code_nx  = next_zero ? END_RETRY : END_DISC;
                end else if (expire) begin
                    state_nx = ST_TERM;
                    code_nx  = END_MABORT;
                end
            end
            ST_TERM: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= END_OK;
            wind_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            code_q  <= code_nx;
            wind_q  <= wind_nx;
        end
    end

    assign state   = state_q;
    assign outcome = code_q;
endmodule

// File: rtl/burst_initiator.sv
// Burst initiator top: latches a client request, then drives the address
// phase and the data phases of a shared address/data bus. It reports the
// outcome and word count. Bus inputs are assumed synchronous to clk.
module burst_initiator
    import burst_init_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int TMO   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_cmd,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic [AW-1:0]    wr_data,
    output logic [AW-1:0]    rd_data,
    output logic             xfer,
    output logic             done,
    output logic [2:0]       done_status,
    output logic [LEN_W-1:0] done_count,
    input  logic             gnt_n,
    output logic             frame_n,
    output logic             irdy_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             dev_sel_n,
    output logic [3:0]       cbe_n,
    output logic [AW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [AW-1:0]    ad_in
);
    ctl_state_t       state;
    end_code_t        outcome;
    logic             final_beat;
    logic             last_one, next_zero, next_full, expire;
    logic             in_addr, in_data, accept;
    logic [3:0]       cmd_q;
    logic [AW-1:0]    addr_q;
    logic [LEN_W-1:0] len_q;
    logic             is_wr;

    assign in_addr = (state == ST_ADDR);
    assign in_data = (state == ST_DATA);
    assign accept  = (state == ST_IDLE) && req_valid;
    assign is_wr   = cmd_q[0];
    assign xfer    = in_data && !trdy_n && !dev_sel_n;

    // Request capture when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            len_q  <= '0;
        end else if (accept) begin
            cmd_q  <= req_cmd;
            addr_q <= req_addr;
            len_q  <= req_len;
        end
    end

    bi_seq_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .gnt_n      (gnt_n),
        .stop_n     (stop_n),
        .dev_sel_n  (dev_sel_n),
        .move       (xfer),
        .last_one   (last_one),
        .next_zero  (next_zero),
        .next_full  (next_full),
        .expire     (expire),
        .state      (state),
        .final_beat (final_beat),
        .outcome    (outcome)
    );

    bi_word_tracker #(.LEN_W(LEN_W)) u_words (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_addr),
        .len       (len_q),
        .step      (xfer),
        .moved     (done_count),
        .last_one  (last_one),
        .next_zero (next_zero),
        .next_full (next_full)
    );

    bi_claim_timer #(.TMO(TMO)) u_claim (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (in_addr),
        .active  (in_data),
        .claim_n (dev_sel_n),
        .expire  (expire)
    );

    // Bus drive decode from the current state.
    always_comb begin
        frame_n = !(in_addr || (in_data && !final_beat));
        irdy_n  = !in_data;
        ad_oe   = in_addr || (in_data && is_wr);
        ad_out  = '0;
        cbe_n   = BE_NONE;
        if (in_addr) begin
            ad_out = addr_q;
            cbe_n  = cmd_q;
        end else if (in_data) begin
            cbe_n = BE_ALL;
            if (is_wr) ad_out = wr_data;
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign done        = (state == ST_TERM);
    assign done_status = outcome;
    assign rd_data     = ad_in;
endmodule

// File: rtl/burst_initiator_chk.sv
// Protocol checker for burst_initiator, attached by bind below.
module burst_initiator_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             trdy_n,
    input logic             dev_sel_n,
    input logic             ad_oe,
    input logic             xfer,
    input logic             done,
    input logic [2:0]       done_status,
    input logic [LEN_W-1:0] done_count
);
    // R1: an idle controller keeps the bus released
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (frame_n && irdy_n && !done));

    // R2: the burst opens with an address cycle, not a data cycle
    assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> (irdy_n && ad_oe));

    // R3: a word only moves with both readies and a claim
    assert_move_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (!irdy_n && !trdy_n && !dev_sel_n));

    // R4: after the final word the bus is released and done is raised
    assert_last_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !trdy_n && !dev_sel_n && frame_n) |=> (irdy_n && frame_n && done));

    // R4: frame_n never returns low within the same data phase
    assert_frame_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && !irdy_n) |=> frame_n);

    // R6: a retry reports zero words
    assert_retry_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == 3'd1) |-> (done_count == '0));

    // R8 and R10: aborts report zero words
    assert_abort_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (done_status == 3'd4 || done_status == 3'd5)) |-> (done_count == '0));

    // R4: done lasts exactly one cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind burst_initiator burst_initiator_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .trdy_n      (trdy_n),
    .dev_sel_n   (dev_sel_n),
    .ad_oe       (ad_oe),
    .xfer        (xfer),
    .done        (done),
    .done_status (done_status),
    .done_count  (done_count)
);

// File: tb/sim_burst_initiator.sv
`timescale 1ns/1ps
module sim_burst_initiator;
    localparam int AW = 32;
    localparam int LEN_W = 16;
    localparam int TMO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic req_ready;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] rd_data;
    logic xfer, done;
    logic [2:0] done_status;
    logic [LEN_W-1:0] done_count;
    logic gnt_n = 1'b0;
    logic frame_n, irdy_n;
    logic trdy_n = 1'b1;
    logic stop_n = 1'b1;
    logic dev_sel_n = 1'b1;
    logic [3:0] cbe_n;
    logic [AW-1:0] ad_out;
    logic ad_oe;
    logic [AW-1:0] ad_in = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_initiator #(.AW(AW), .LEN_W(LEN_W), .TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
        .wr_data(wr_data), .rd_data(rd_data), .xfer(xfer), .done(done),
        .done_status(done_status), .done_count(done_count), .gnt_n(gnt_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .dev_sel_n(dev_sel_n), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Accept a request, hold the grant back for gnt_wait cycles, check the address cycle.
    task automatic start_req(input logic [3:0] cmd, input logic [31:0] addr,
                             input int len, input int gnt_wait);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
        gnt_n = (gnt_wait > 0);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len);
        step();
        req_valid = 1'b0;
        for (int k = 0; k < gnt_wait; k++) begin
            chk(frame_n == 1'b1, "R12", "frame_n without grant", frame_n, 1);
            step();
        end
        gnt_n = 1'b0;
        step();
        chk(frame_n == 1'b0 && irdy_n == 1'b1 && ad_oe == 1'b1, "R2", "address cycle controls",
            {frame_n, irdy_n, ad_oe}, 3'b011);
        chk(ad_out == addr && cbe_n == cmd, "R2", "address and command",
            {cbe_n, ad_out}, {cmd, addr});
        step();
    endtask

    // Drive the target side through the data phase and collect the outcome.
    task automatic run_data(input int len, input bit wr, input int claim_d, input bit waits,
                            input int stop_at, input bit stop_data, input int gnt_at,
                            output int nx, output logic [2:0] st, output int cnt);
        nx = 0; st = 3'd7; cnt = -1;
        for (int i = 0; i < 64; i++) begin
            if (done) begin
                chk(irdy_n && frame_n, "R4", "bus released at done", {irdy_n, frame_n}, 2'b11);
                st = done_status; cnt = int'(done_count);
                break;
            end
            if (i == 0)
                chk(irdy_n == 1'b0 && cbe_n == 4'b0000, "R2", "first data cycle",
                    {irdy_n, cbe_n}, 5'b0);
            if (gnt_at >= 0 && i == gnt_at + 1)
                chk(frame_n == 1'b1, "R9", "frame_n after grant loss", frame_n, 1);
            dev_sel_n = (i < claim_d);
            trdy_n = dev_sel_n | (waits && (i % 2 == 0));
            stop_n = 1'b1;
            if (i == stop_at) begin
                stop_n = 1'b0;
                trdy_n = !stop_data | dev_sel_n;
            end
            gnt_n = (gnt_at >= 0 && i >= gnt_at);
            wr_data = 32'hA000_0000 + nx;
            ad_in = 32'hB000_0000 + nx;
            #1;
            if (gnt_at < 0 && stop_at < 0 && !irdy_n)
                chk(frame_n == (nx == len - 1), "R4", "frame_n on last word", frame_n, nx == len - 1);
            if (!irdy_n && !trdy_n && !dev_sel_n) begin
                chk(xfer == 1'b1, "R3", "xfer strobe", xfer, 1);
                if (wr)
                    chk(ad_oe && ad_out == 32'hA000_0000 + nx, "R5", "write word",
                        ad_out, 32'hA000_0000 + nx);
                else
                    chk(!ad_oe && rd_data == 32'hB000_0000 + nx, "R5", "read word",
                        rd_data, 32'hB000_0000 + nx);
                nx++;
            end else begin
                chk(xfer == 1'b0, "R3", "no move in wait", xfer, 0);
                if (wr && !irdy_n)
                    chk(ad_out == 32'hA000_0000 + nx, "R3", "write word held", ad_out,
                        32'hA000_0000 + nx);
            end
            step();
        end
        trdy_n = 1'b1; stop_n = 1'b1; dev_sel_n = 1'b1; gnt_n = 1'b0;
        step();
    endtask

    task automatic scenario(input string req, input logic [3:0] cmd, input int len,
                            input int claim_d, input bit waits, input int stop_at,
                            input bit stop_data, input int gnt_at,
                            input logic [2:0] exp_st, input int exp_cnt);
        int nx, cnt;
        logic [2:0] st;
        start_req(cmd, 32'h1000_0040 + len, len, 0);
        run_data(len, cmd[0], claim_d, waits, stop_at, stop_data, gnt_at, nx, st, cnt);
        chk(st == exp_st, req, "outcome code", st, exp_st);
        chk(cnt == exp_cnt, req, "reported count", cnt, exp_cnt);
        chk(nx == exp_cnt, req, "words seen on bus", nx, exp_cnt);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(frame_n && irdy_n && !ad_oe && !done, "R1", "reset outputs",
            {frame_n, irdy_n, ad_oe, done}, 4'b1100);
    endtask

    task automatic t_no_grant();
        int nx, cnt;
        logic [2:0] st;
        start_req(4'b0111, 32'h2000_0000, 2, 5);
        run_data(2, 1'b1, 0, 1'b0, -1, 1'b0, -1, nx, st, cnt);
        chk(st == 3'd0 && cnt == 2, "R12", "burst after late grant", {st, 16'(cnt)}, {3'd0, 16'd2});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        scenario("R4", 4'b0111, 4, 0, 1'b0, -1, 1'b0, -1, 3'd0, 4);   // plain write burst
        scenario("R5", 4'b0110, 3, 2, 1'b1, -1, 1'b0, -1, 3'd0, 3);   // read, late claim, waits
        scenario("R4", 4'b0111, 1, 0, 1'b0, -1, 1'b0, -1, 3'd0, 1);   // single word
        scenario("R6", 4'b0111, 4, 0, 1'b0, 0, 1'b0, -1, 3'd1, 0);    // retry
        scenario("R7", 4'b0110, 6, 0, 1'b0, 2, 1'b1, -1, 3'd2, 3);    // disconnect with data
        scenario("R8", 4'b0111, 4, 99, 1'b0, 1, 1'b0, -1, 3'd4, 0);   // target abort
        scenario("R10", 4'b0110, 4, 99, 1'b0, -1, 1'b0, -1, 3'd5, 0); // master abort
        scenario("R9", 4'b0111, 8, 0, 1'b0, -1, 1'b0, 2, 3'd3, 4);    // grant withdrawn
        scenario("R11", 4'b0111, 2, 0, 1'b0, 1, 1'b1, -1, 3'd0, 2);   // stop on final word
        t_no_grant();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule